// File: doc/BRIEF.md
# I2C Slave Register-Access Controller

This block is a slave-side front end for a two-wire serial bus. It turns bus transactions into single-cycle strobes on a parallel register port. SCL and SDA are oversampled by the system clock through short synchronizer chains. From the synchronized levels the block recognises START, repeated START and STOP conditions and the clock edges. The slave answers to a 7-bit device address whose upper five bits are fixed at `01010`. Its two lowest bits come from strap inputs, which can be used in a two-bit configuration mode or a single-pin mode.

In a write transfer, the first byte after the device address is a register index. Every following byte is written to the register at the current index, and the index then moves to the next register. There is one exception: a designated FIFO index, where the pointer holds still so that a burst of bytes goes into one location. A read returns bytes starting at the stored pointer, MSB first. This pointer is either the one just loaded by a write-mode address phase or, when that phase is skipped, the one left over from the previous transfer. The slave pulls SDA low only through an open-drain output enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: In configuration mode (`pin_mode`=0) the device address is `{01010, addr_sel[1], addr_sel[0]}`. A matching address byte is acknowledged by asserting `sda_oe` for the ninth SCL clock.
- R2: A non-matching address byte is not acknowledged. Until the next START or STOP, `sda_oe`, `wr_en` and `rd_en` all stay low.
- R3: In a write, bits 6..0 of the first byte after the address set the register pointer. Each later byte is acknowledged and written with a one-cycle `wr_en` at `reg_addr` = pointer. The pointer then advances by one, wrapping modulo 128.
- R4: When the pointer equals the FIFO index (default 0x05), it does not advance after a write or a read.
- R5: A read issues a one-cycle `rd_en` at `reg_addr` = pointer before the first bit of each byte. It takes `rd_data` one clock later and sends the byte MSB first. The pointer advances after each read, as in R3 and R4.
- R6: The pointer is kept across STOP. A read with no address phase starts from the stored pointer.
- R7: In pin mode (`pin_mode`=1) address bit 1 is forced to 0, and bit 0 follows `addr_sel[0]`.
- R8: A START or repeated START at any point abandons the byte in progress and begins a new device-address phase.
- R9: After the master NACKs a read byte, no further `rd_en` is issued and SDA stays released until the next START.
- R10: `sda_oe` changes only while SCL is low, or in response to a START or STOP.
- R11: After reset, `sda_oe`, `wr_en` and `rd_en` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pin_mode | input | 1 | 1 selects single-pin strap mode for the address |
| addr_sel | input | 2 | Strap bits for the two low address bits |
| reg_addr | output | 7 | Register index for the current access |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Data for the write strobe |
| rd_en | output | 1 | One-cycle read strobe |
| rd_data | input | 8 | Read data, valid one clock after `rd_en` |

## Verification
Some properties are checked by assertions on every cycle: `sda_oe` moves only while the synchronized SCL is low, the block stays silent while it is ignoring the bus, read and write strobes never overlap, and the pointer steps by one everywhere except at the FIFO index. Other behaviour only shows up in the bench's transactions. These are the address match in both strap modes, the order of data in bursts, reuse of the pointer across STOP, recovery after an aborted byte, and silence after a master NACK.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [6:0] dev_addr(input logic [4:0] hi,
                                            input logic [1:0] sel,
                                            input logic       pin_mode);
        return {hi, (pin_mode ? 1'b0 : sel[1]), sel[0]};
    endfunction
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync
    import i2cr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    logic scl_s, scl_p, sda_s, sda_p;
    assign scl_s = scl_q[STAGES-1];
    assign scl_p = scl_q[STAGES];
    assign sda_s = sda_q[STAGES-1];
    assign sda_p = sda_q[STAGES];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end

    p_start_stop_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/i2cr_ptr.sv
module i2cr_ptr #(
    parameter int               W        = 7,
    parameter logic [W-1:0]     FIFO_IDX = 7'h05
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step && ptr != FIFO_IDX)
            ptr <= ptr + 1'b1;
    end

    p_step_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr != FIFO_IDX) |=> (ptr == W'($past(ptr) + 1'b1)));
    p_fifo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr == FIFO_IDX) |=> (ptr == FIFO_IDX));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(ptr));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2cr_pkg::*;
#(
    parameter logic [4:0]       DEV_HI      = 5'b01010,
    parameter logic [IDX_W-1:0] FIFO_IDX    = 7'h05,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pin_mode,
    input  logic [1:0]        addr_sel,
    output logic [IDX_W-1:0]  reg_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_ev_t ev;

    i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev   (ev)
    );

    phase_t             st;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic               ack_ph;
    logic               rw;
    logic               mack;
    logic               oe_q;
    logic               wr_q;
    logic               rd_q;
    logic               rd_pend;
    logic [BYTE_W-1:0]  wdat_q;
    logic               ld_q;
    logic [IDX_W-1:0]   ld_val;
    logic [BYTE_W-1:0]  rx_full;
    logic [6:0]         my_addr;

    assign rx_full = {rx_sh[BYTE_W-2:0], ev.sda};
    assign my_addr = dev_addr(DEV_HI, addr_sel, pin_mode);

    i2cr_ptr #(.W(IDX_W), .FIFO_IDX(FIFO_IDX)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ld_q),
        .load_val(ld_val),
        .step    (wr_q | rd_q),
        .ptr     (reg_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ack_ph  <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            oe_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            rd_pend <= 1'b0;
            wdat_q  <= '0;
            ld_q    <= 1'b0;
            ld_val  <= '0;
        end else begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            ld_q    <= 1'b0;
            rd_pend <= rd_q;
            if (rd_pend)
                tx_sh <= rd_data;

            if (ev.start) begin
                st     <= ST_DEV;
                cnt    <= '0;
                oe_q   <= 1'b0;
                ack_ph <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                oe_q   <= 1'b0;
                ack_ph <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_REG, ST_WDAT: begin
                        if (ev.rise) begin
                            rx_sh <= rx_full;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                ack_ph <= 1'b0;
                                if (st == ST_DEV) begin
                                    if (rx_full[7:1] == my_addr) begin
                                        st <= ST_DEV_ACK;
                                        rw <= rx_full[0];
                                        rd_q <= rx_full[0];
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end else if (st == ST_REG) begin
                                    ld_q   <= 1'b1;
                                    ld_val <= rx_full[IDX_W-1:0];
                                    st     <= ST_REG_ACK;
                                end else begin
                                    wr_q   <= 1'b1;
                                    wdat_q <= rx_full;
                                    st     <= ST_WDAT_ACK;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: begin
                        if (ev.fall) begin
                            if (!ack_ph) begin
                                ack_ph <= 1'b1;
                                oe_q   <= 1'b1;
                            end else begin
                                ack_ph <= 1'b0;
                                cnt    <= '0;
                                if (st == ST_DEV_ACK && rw) begin
                                    st   <= ST_TX;
                                    oe_q <= ~tx_sh[BYTE_W-1];
                                end else begin
                                    st   <= (st == ST_DEV_ACK) ? ST_REG : ST_WDAT;
                                    oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                st     <= ST_TX_ACK;
                                ack_ph <= 1'b0;
                            end
                        end else if (ev.fall) begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise) begin
                            ack_ph <= 1'b1;
                            mack   <= ~ev.sda;
                            rd_q   <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (!ack_ph) begin
                                oe_q <= 1'b0;
                            end else if (mack) begin
                                st     <= ST_TX;
                                cnt    <= '0;
                                ack_ph <= 1'b0;
                                oe_q   <= ~tx_sh[BYTE_W-1];
                            end else begin
                                st     <= ST_IDLE;
                                ack_ph <= 1'b0;
                                oe_q   <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_q;
    assign wr_data = wdat_q;
    assign rd_en   = rd_q;

    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> (!$past(ev.scl) || $past(ev.start) || $past(ev.stop)));
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!oe_q && !wr_q && !rd_q));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_q && rd_q));
    p_rd_single_r5: assert property (@(posedge clk) disable iff (rst)
        rd_q |=> !rd_q);
    p_no_read_after_nack_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_TX_ACK && st == ST_IDLE) |-> !oe_q);
endmodule

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
    localparam int CLK_NS = 10;
    localparam int HALF   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pin_mode = 1'b0;
    logic [1:0] addr_sel = 2'b10;
    logic       sda_oe, wr_en, rd_en;
    logic [6:0] reg_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data = 8'h00;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    i2c_reg_slave u0 (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .pin_mode(pin_mode),
        .addr_sel(addr_sel),
        .reg_addr(reg_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    int vectors = 0;
    int miscompares = 0;
    int oe_viol = 0;
    int rd_cnt = 0;
    logic [7:0] mem [128];
    logic [6:0] wa_q[$];
    logic [7:0] wd_q[$];
    logic [6:0] ea_q[$];
    logic [7:0] ed_q[$];

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 7);
    end

    // behavioural register file and strobe log
    always @(posedge clk) begin
        if (!rst && wr_en) begin
            mem[reg_addr] <= wr_data;
            wa_q.push_back(reg_addr);
            wd_q.push_back(wr_data);
        end
        if (!rst && rd_en) begin
            rd_data <= mem[reg_addr];
            rd_cnt  <= rd_cnt + 1;
        end
    end

    // per-clock comparison: SDA drive may only move while SCL is low (R10)
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && scl_m) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
        sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
    endtask

    task automatic send_bits(input int n, input logic [7:0] b);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(8, b);
        sda_m = 1'b1; hw(); scl_m = 1'b1;
        repeat (HALF/2) @(negedge clk);
        ack = ~sda_line;
        repeat (HALF/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(); scl_m = 1'b1;
            repeat (HALF/2) @(negedge clk);
            b = {b[6:0], sda_line};
            repeat (HALF/2) @(negedge clk);
            scl_m = 1'b0;
        end
        repeat (2) @(negedge clk);
        sda_m = ~give_ack; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
    endtask

    task automatic cmp_writes(input string req);
        chk(wa_q.size() == ea_q.size(), req, wa_q.size(), ea_q.size());
        if (wa_q.size() == ea_q.size()) begin
            for (int i = 0; i < ea_q.size(); i++) begin
                chk(wa_q[i] == ea_q[i], req, wa_q[i], ea_q[i]);
                chk(wd_q[i] == ed_q[i], req, wd_q[i], ed_q[i]);
            end
        end
        wa_q.delete(); wd_q.delete(); ea_q.delete(); ed_q.delete();
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        int rd_before;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 oe", sda_oe, 0);
        chk(wr_en == 1'b0 && rd_en == 1'b0, "R11 strobes", {wr_en, rd_en}, 0);
        chk(reg_addr == 7'h00, "R11 ptr", reg_addr, 0);

        // R1 + R3: config mode address 0x2A, burst write from 0x10
        bus_start();
        send_byte(8'h54, a); chk(a == 1'b1, "R1 addr ack", a, 1);
        send_byte(8'h10, a); chk(a == 1'b1, "R3 reg ack", a, 1);
        send_byte(8'hAA, a); chk(a == 1'b1, "R3 data ack", a, 1);
        send_byte(8'hBB, a);
        send_byte(8'hCC, a);
        bus_stop(); hw();
        ea_q = '{7'h10, 7'h11, 7'h12}; ed_q = '{8'hAA, 8'hBB, 8'hCC};
        cmp_writes("R3 burst");

        // R4: FIFO index holds the pointer
        bus_start();
        send_byte(8'h54, a); send_byte(8'h05, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        bus_stop(); hw();
        ea_q = '{7'h05, 7'h05, 7'h05}; ed_q = '{8'h11, 8'h22, 8'h33};
        cmp_writes("R4 fifo");

        // R2: mismatched address ignored
        bus_start();
        send_byte(8'h56, a); chk(a == 1'b0, "R2 nack", a, 0);
        send_byte(8'h10, a); chk(a == 1'b0, "R2 no ack", a, 0);
        send_byte(8'h99, a);
        bus_stop(); hw();
        cmp_writes("R2 no writes");

        // R5 + R9: read with address phase, repeated START
        rd_before = rd_cnt;
        bus_start();
        send_byte(8'h54, a); send_byte(8'h10, a);
        bus_start();
        send_byte(8'h55, a); chk(a == 1'b1, "R5 read addr ack", a, 1);
        recv_byte(1'b1, d); chk(d == 8'hAA, "R5 byte0", d, 8'hAA);
        recv_byte(1'b1, d); chk(d == 8'hBB, "R5 byte1", d, 8'hBB);
        recv_byte(1'b0, d); chk(d == 8'hCC, "R5 byte2", d, 8'hCC);
        recv_byte(1'b0, d); chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
        bus_stop(); hw();
        chk(rd_cnt - rd_before == 3, "R9 read count", rd_cnt - rd_before, 3);

        // R6: pointer kept across STOP, read without address phase
        bus_start();
        send_byte(8'h54, a); send_byte(8'h40, a);
        bus_stop(); hw();
        bus_start();
        send_byte(8'h55, a);
        recv_byte(1'b0, d);
        bus_stop(); hw();
        chk(d == 8'(8'h40 * 3 + 7), "R6 stored pointer", d, 8'(8'h40 * 3 + 7));

        // R6 + R4: reuse of FIFO pointer
        bus_start();
        send_byte(8'h54, a); send_byte(8'h05, a);
        bus_stop(); hw();
        bus_start();
        send_byte(8'h55, a);
        recv_byte(1'b1, d); chk(d == 8'h33, "R4 fifo read0", d, 8'h33);
        recv_byte(1'b0, d); chk(d == 8'h33, "R4 fifo read1", d, 8'h33);
        bus_stop(); hw();

        // R8: aborted byte then repeated START
        bus_start();
        send_bits(4, 8'hF0);
        bus_start();
        send_byte(8'h54, a); chk(a == 1'b1, "R8 ack after abort", a, 1);
        send_byte(8'h30, a); send_byte(8'h5A, a);
        bus_stop(); hw();
        ea_q = '{7'h30}; ed_q = '{8'h5A};
        cmp_writes("R8 write after abort");

        // R1 second pattern: config mode, straps 11 -> 0x2B
        addr_sel = 2'b11;
        bus_start(); send_byte(8'h56, a); bus_stop(); hw();
        chk(a == 1'b1, "R1 addr 2B", a, 1);

        // R7: pin mode forces bit1 to 0
        pin_mode = 1'b1;
        bus_start(); send_byte(8'h52, a); bus_stop(); hw();
        chk(a == 1'b1, "R7 addr 29 ack", a, 1);
        bus_start(); send_byte(8'h56, a); bus_stop(); hw();
        chk(a == 1'b0, "R7 addr 2B nack", a, 0);

        chk(oe_viol == 0, "R10 oe while scl high", oe_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule